// File: doc/BRIEF.md
# Panel Power and Resolution Command Sequencer

This block drives the bring-up, shut-down and resolution changes of a display panel. Its command scripts sit in an internal constant table. Each entry holds an opcode, a parameter count of 0 to 2, and up to two parameter bytes. A count of 3 marks the end of a script. The sequencer chains scripts in a fixed order and offers one command at a time to a downstream frame serializer over a valid/ready stream.

The command stream follows the usual back-pressure rules. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high and `xfer_err` is low. While `cmd_valid` is high and the command has not been taken, the command fields hold steady. The serializer can raise `xfer_err` for one cycle to report a failed transfer. That aborts the running sequence.

Power requests compare the requested on/off level with the stored power state. Resolution requests give a horizontal pixel count, which selects full or quarter resolution. Only a real change starts work. Completion is reported with a one-cycle `seq_done` pulse and an abort with a one-cycle `seq_err` pulse. Requests that cannot be taken produce a one-cycle `seq_reject` pulse.

Top module: `panel_init_seq`

## Requirements
- R1: A power-up runs, in order, the panel-on script (first opcode 0x29), the reset script (opcodes 0x01, 0x00, 0x00, 0x00), and then the three resolution scripts for the stored resolution.
- R2: The resolution scripts run in the order pass-through setup (opcode 0xB0, then 0xBC with parameter 0x80 for full or 0x81 for quarter), then common configuration (first opcode 0xB8), then timing transfer (first opcode 0xCF for full, 0xD6 for quarter; last opcode 0x29).
- R3: A power-down runs only the panel-off script, which has 4 commands and first opcode 0x28.
- R4: After reset, power is off, the stored resolution is full, `busy` is 0, and `cmd_valid`, `seq_done`, `seq_err` and `seq_reject` are 0.
- R5: A power request that matches the stored on/off state starts nothing: `busy` stays 0 and no command is offered.
- R6: A resolution request whose `hres` is 640 or 480 selects full. Any other value selects quarter. A change runs the three resolution scripts, which give 16 commands when inversion is enabled.
- R7: A resolution request equal to the stored resolution does nothing.
- R8: A zero-parameter command with opcode 0x21 is dropped without being offered when `invert_en`, sampled at the start of the sequence, is 0. With inversion off, a power-up gives 23 commands instead of 24.
- R9: A cycle with `xfer_err` high accepts no command and ends the sequence. It raises `seq_err` and not `seq_done`, and the stored state stays unchanged, so a repeated power-up request runs in full.
- R10: A power or resolution request made while `busy` is ignored, and `seq_reject` pulses for one cycle. A resolution request in the same idle cycle as a power request is likewise rejected.
- R11: While `cmd_valid` is high and not accepted, the command fields stay stable, and back-pressure loses or repeats no command.
- R12: Each finished sequence gives exactly one `seq_done` pulse, in the cycle after `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_req | input | 1 | Power request strobe |
| pwr_on | input | 1 | Requested power level (1 = on) |
| mode_req | input | 1 | Resolution request strobe |
| hres | input | 12 | Requested horizontal resolution in pixels |
| invert_en | input | 1 | Enables the colour-inversion command |
| cmd_valid | output | 1 | Command offered to serializer |
| cmd_ready | input | 1 | Serializer can accept the command |
| cmd_op | output | 8 | Command opcode |
| cmd_cnt | output | 2 | Number of parameter bytes (0..2) |
| cmd_p0 | output | 8 | First parameter byte |
| cmd_p1 | output | 8 | Second parameter byte |
| xfer_err | input | 1 | Serializer transfer failure strobe |
| busy | output | 1 | A sequence is running |
| seq_done | output | 1 | One-cycle pulse on successful completion |
| seq_err | output | 1 | One-cycle pulse on abort |
| seq_reject | output | 1 | One-cycle pulse on a dropped request |

## Verification
The bench logs every accepted command and compares the order of the scripts against the rules for power-up, power-down and resolution changes. A design with the wrong chaining would show the reset opcodes or the configuration header at the wrong index. Repeated power and resolution requests, including two different widths that both map to quarter, expose a design that re-runs scripts on a request that changes nothing. An error injected part way through must leave exactly the commands taken before it, and a later power-up must run in full. A design that commits state on abort would stay silent on that later request. A request made during a power-down must be rejected and must not change the stored resolution. The inversion skip is checked under toggling back-pressure, where a lost or repeated command changes the count.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;
  localparam int OP_W  = 8;
  localparam int CNT_W = 2;

  typedef struct packed {
    logic [CNT_W-1:0] cnt;
    logic [OP_W-1:0]  op;
    logic [OP_W-1:0]  p0;
    logic [OP_W-1:0]  p1;
  } seq_entry_t;

  localparam logic [CNT_W-1:0] CNT_END   = 2'd3;
  localparam logic [OP_W-1:0]  OP_INVERT = 8'h21;

  typedef enum logic [2:0] {
    SC_ON, SC_RST, SC_OFF, SC_PTF, SC_PTQ, SC_CFG, SC_TMF, SC_TMQ
  } script_t;

  typedef enum logic [1:0] { JOB_UP, JOB_DOWN, JOB_MODE } job_t;

  typedef enum logic [1:0] { ST_IDLE, ST_LOAD, ST_RUN } seq_state_t;

  function automatic seq_entry_t mk(input logic [1:0] c, input logic [7:0] o,
                                    input logic [7:0] a, input logic [7:0] b);
    seq_entry_t e;
    e.cnt = c; e.op = o; e.p0 = a; e.p1 = b;
    return e;
  endfunction
endpackage

// File: rtl/panel_script_rom.sv
module panel_script_rom
  import panel_seq_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output seq_entry_t        ent
);
  always_comb begin
    case (addr)
      // panel on
      6'd0:  ent = mk(2'd0, 8'h29, 8'h00, 8'h00);
      6'd1:  ent = mk(2'd2, 8'hB8, 8'hFF, 8'hF9);
      6'd2:  ent = mk(2'd0, 8'h11, 8'h00, 8'h00);
      6'd3:  ent = mk(2'd1, 8'hB0, 8'h16, 8'h00);
      // reset
      6'd5:  ent = mk(2'd0, 8'h01, 8'h00, 8'h00);
      6'd6:  ent = mk(2'd0, 8'h00, 8'h00, 8'h00);
      6'd7:  ent = mk(2'd0, 8'h00, 8'h00, 8'h00);
      6'd8:  ent = mk(2'd0, 8'h00, 8'h00, 8'h00);
      // panel off
      6'd10: ent = mk(2'd0, 8'h28, 8'h00, 8'h00);
      6'd11: ent = mk(2'd2, 8'hB8, 8'h80, 8'h02);
      6'd12: ent = mk(2'd0, 8'h10, 8'h00, 8'h00);
      6'd13: ent = mk(2'd1, 8'hB0, 8'h00, 8'h00);
      // pass-through, full
      6'd15: ent = mk(2'd1, 8'hB0, 8'h16, 8'h00);
      6'd16: ent = mk(2'd1, 8'hBC, 8'h80, 8'h00);
      6'd17: ent = mk(2'd1, 8'hE1, 8'h00, 8'h00);
      6'd18: ent = mk(2'd1, 8'h36, 8'h50, 8'h00);
      6'd19: ent = mk(2'd1, 8'h3B, 8'h00, 8'h00);
      // pass-through, quarter
      6'd21: ent = mk(2'd1, 8'hB0, 8'h16, 8'h00);
      6'd22: ent = mk(2'd1, 8'hBC, 8'h81, 8'h00);
      6'd23: ent = mk(2'd1, 8'hE1, 8'h00, 8'h00);
      6'd24: ent = mk(2'd1, 8'h36, 8'h50, 8'h00);
      6'd25: ent = mk(2'd1, 8'h3B, 8'h22, 8'h00);
      // common configuration
      6'd27: ent = mk(2'd2, 8'hB8, 8'hFF, 8'hF9);
      6'd28: ent = mk(2'd0, 8'h11, 8'h00, 8'h00);
      6'd29: ent = mk(2'd1, 8'hBA, 8'h01, 8'h00);
      6'd30: ent = mk(2'd1, 8'h3A, 8'h60, 8'h00);
      6'd31: ent = mk(2'd1, 8'hB1, 8'h56, 8'h00);
      6'd32: ent = mk(2'd2, 8'hEC, 8'h01, 8'hF0);
      // timing transfer, full
      6'd34: ent = mk(2'd1, 8'hCF, 8'h02, 8'h00);
      6'd35: ent = mk(2'd2, 8'hD0, 8'h08, 8'h04);
      6'd36: ent = mk(2'd1, 8'hD5, 8'h14, 8'h00);
      6'd37: ent = mk(2'd0, 8'h21, 8'h00, 8'h00);
      6'd38: ent = mk(2'd0, 8'h29, 8'h00, 8'h00);
      // timing transfer, quarter
      6'd40: ent = mk(2'd1, 8'hD6, 8'h02, 8'h00);
      6'd41: ent = mk(2'd2, 8'hD7, 8'h08, 8'h04);
      6'd42: ent = mk(2'd1, 8'hE0, 8'h0A, 8'h00);
      6'd43: ent = mk(2'd0, 8'h21, 8'h00, 8'h00);
      6'd44: ent = mk(2'd0, 8'h29, 8'h00, 8'h00);
      default: ent = mk(CNT_END, 8'h00, 8'h00, 8'h00);
    endcase
  end
endmodule

// File: rtl/panel_job_plan.sv
module panel_job_plan
  import panel_seq_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int STEP_W = 3
) (
  input  job_t              job,
  input  logic [STEP_W-1:0] step,
  input  logic              full,
  output logic [ADDR_W-1:0] base,
  output logic              last
);
  localparam logic [STEP_W-1:0] UP_LAST   = STEP_W'(4);
  localparam logic [STEP_W-1:0] MODE_SKIP = STEP_W'(2);

  logic [STEP_W-1:0] idx;
  script_t           scr;

  always_comb begin
    idx = (job == JOB_MODE) ? step + MODE_SKIP : step;
    if (job == JOB_DOWN) begin
      scr  = SC_OFF;
      last = 1'b1;
    end else begin
      last = (idx == UP_LAST);
      case (idx)
        STEP_W'(0): scr = SC_ON;
        STEP_W'(1): scr = SC_RST;
        STEP_W'(2): scr = full ? SC_PTF : SC_PTQ;
        STEP_W'(3): scr = SC_CFG;
        default:    scr = full ? SC_TMF : SC_TMQ;
      endcase
    end
    case (scr)
      SC_ON:   base = ADDR_W'(0);
      SC_RST:  base = ADDR_W'(5);
      SC_OFF:  base = ADDR_W'(10);
      SC_PTF:  base = ADDR_W'(15);
      SC_PTQ:  base = ADDR_W'(21);
      SC_CFG:  base = ADDR_W'(27);
      SC_TMF:  base = ADDR_W'(34);
      default: base = ADDR_W'(40);
    endcase
  end
endmodule

// File: rtl/panel_seq_ctrl.sv
module panel_seq_ctrl
  import panel_seq_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_req,
  input  logic              pwr_on,
  input  logic              mode_req,
  input  logic              want_full,
  input  logic              invert_en,
  input  logic              cmd_ready,
  input  logic              xfer_err,
  input  seq_entry_t        ent,
  input  logic [ADDR_W-1:0] plan_base,
  input  logic              plan_last,
  output logic [ADDR_W-1:0] addr_q,
  output job_t              job_q,
  output logic [STEP_W-1:0] step_q,
  output logic              tfull_q,
  output logic              inv_q,
  output logic              cmd_valid,
  output logic              busy,
  output logic              seq_done,
  output logic              seq_err,
  output logic              seq_reject
);
  seq_state_t st_q;
  logic pwr_q, full_q;
  logic is_end, skip, pwr_go, mode_go;

  assign busy      = (st_q != ST_IDLE);
  assign is_end    = (ent.cnt == CNT_END);
  assign skip      = !inv_q && (ent.cnt == 2'd0) && (ent.op == OP_INVERT);
  assign cmd_valid = (st_q == ST_RUN) && !is_end && !skip;
  assign pwr_go    = pwr_req && (pwr_on != pwr_q);
  assign mode_go   = !pwr_req && mode_req && (want_full != full_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      job_q      <= JOB_UP;
      step_q     <= '0;
      addr_q     <= '0;
      tfull_q    <= 1'b1;
      inv_q      <= 1'b0;
      pwr_q      <= 1'b0;
      full_q     <= 1'b1;
      seq_done   <= 1'b0;
      seq_err    <= 1'b0;
      seq_reject <= 1'b0;
    end else begin
      seq_done   <= 1'b0;
      seq_err    <= 1'b0;
      seq_reject <= busy ? (pwr_req || mode_req) : (pwr_req && mode_req);
      case (st_q)
        ST_IDLE: begin
          if (pwr_go || mode_go) begin
            st_q    <= ST_LOAD;
            step_q  <= '0;
            inv_q   <= invert_en;
            job_q   <= pwr_go ? (pwr_on ? JOB_UP : JOB_DOWN) : JOB_MODE;
            tfull_q <= pwr_go ? full_q : want_full;
          end
        end
        ST_LOAD: begin
          if (xfer_err) begin
            st_q    <= ST_IDLE;
            seq_err <= 1'b1;
          end else begin
            addr_q <= plan_base;
            st_q   <= ST_RUN;
          end
        end
        default: begin
          if (xfer_err) begin
            st_q    <= ST_IDLE;
            seq_err <= 1'b1;
          end else if (is_end) begin
            if (plan_last) begin
              st_q     <= ST_IDLE;
              seq_done <= 1'b1;
              if (job_q == JOB_MODE) full_q <= tfull_q;
              else                   pwr_q  <= (job_q == JOB_UP);
            end else begin
              step_q <= step_q + 1'b1;
              st_q   <= ST_LOAD;
            end
          end else if (skip || cmd_ready) begin
            addr_q <= addr_q + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/panel_init_seq.sv
module panel_init_seq
  import panel_seq_pkg::*;
#(
  parameter int HRES_W  = 12,
  parameter int FULL_A  = 640,
  parameter int FULL_B  = 480,
  parameter int ADDR_W  = 6,
  parameter int STEP_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_req,
  input  logic              pwr_on,
  input  logic              mode_req,
  input  logic [HRES_W-1:0] hres,
  input  logic              invert_en,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [7:0]        cmd_op,
  output logic [1:0]        cmd_cnt,
  output logic [7:0]        cmd_p0,
  output logic [7:0]        cmd_p1,
  input  logic              xfer_err,
  output logic              busy,
  output logic              seq_done,
  output logic              seq_err,
  output logic              seq_reject
);
  seq_entry_t        ent;
  logic [ADDR_W-1:0] addr_q, plan_base;
  logic [STEP_W-1:0] step_q;
  job_t              job_q;
  logic              tfull_q, inv_q, plan_last, want_full;

  assign want_full = (hres == HRES_W'(FULL_A)) || (hres == HRES_W'(FULL_B));

  panel_script_rom #(.ADDR_W(ADDR_W)) u_rom (.addr(addr_q), .ent(ent));

  panel_job_plan #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_plan (
    .job(job_q), .step(step_q), .full(tfull_q),
    .base(plan_base), .last(plan_last)
  );

  panel_seq_ctrl #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req), .pwr_on(pwr_on),
    .mode_req(mode_req), .want_full(want_full), .invert_en(invert_en),
    .cmd_ready(cmd_ready), .xfer_err(xfer_err), .ent(ent),
    .plan_base(plan_base), .plan_last(plan_last), .addr_q(addr_q),
    .job_q(job_q), .step_q(step_q), .tfull_q(tfull_q), .inv_q(inv_q),
    .cmd_valid(cmd_valid), .busy(busy), .seq_done(seq_done),
    .seq_err(seq_err), .seq_reject(seq_reject)
  );

  assign cmd_op  = ent.op;
  assign cmd_cnt = ent.cnt;
  assign cmd_p0  = ent.p0;
  assign cmd_p1  = ent.p1;
endmodule

// File: rtl/panel_init_seq_chk.sv
module panel_init_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [7:0] cmd_op,
  input logic [1:0] cmd_cnt,
  input logic [7:0] cmd_p0,
  input logic [7:0] cmd_p1,
  input logic       xfer_err,
  input logic       busy,
  input logic       seq_done,
  input logic       seq_err,
  input logic       seq_reject,
  input logic       inv_q
);
  // R11
  hold_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready && !xfer_err |=>
      cmd_valid && $stable(cmd_op) && $stable(cmd_p0) && $stable(cmd_p1) && $stable(cmd_cnt));
  // R8
  skip_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_cnt == 2'd0 && cmd_op == 8'h21 |-> inv_q);
  // R9
  excl_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(seq_done && seq_err));
  // R12
  fall_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (seq_done || seq_err));
  // R10
  reject_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_reject |-> !$past(seq_reject) || $past(busy));
  // R4
  valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy);
endmodule

bind panel_init_seq panel_init_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_cnt(cmd_cnt), .cmd_p0(cmd_p0), .cmd_p1(cmd_p1),
  .xfer_err(xfer_err), .busy(busy), .seq_done(seq_done), .seq_err(seq_err),
  .seq_reject(seq_reject), .inv_q(inv_q)
);

// File: tb/panel_init_seq_test.sv
module panel_init_seq_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pwr_req = 0, pwr_on = 0, mode_req = 0, invert_en = 1, xfer_err = 0;
  logic [11:0] hres = 12'd640;
  logic cmd_ready = 1'b1, bp_en = 1'b0;
  logic cmd_valid, busy, seq_done, seq_err, seq_reject;
  logic [7:0] cmd_op, cmd_p0, cmd_p1;
  logic [1:0] cmd_cnt;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int n_log = 0, done_cnt = 0, err_cnt = 0, rej_cnt = 0;
  logic [7:0] op_log [0:511];
  logic [7:0] p0_log [0:511];

  always #(CLK_PERIOD/2) clk = ~clk;

  panel_init_seq uut (
    .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req), .pwr_on(pwr_on),
    .mode_req(mode_req), .hres(hres), .invert_en(invert_en),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_cnt(cmd_cnt), .cmd_p0(cmd_p0), .cmd_p1(cmd_p1),
    .xfer_err(xfer_err), .busy(busy), .seq_done(seq_done),
    .seq_err(seq_err), .seq_reject(seq_reject)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      if (cmd_valid && cmd_ready && !xfer_err) begin
        op_log[n_log[8:0]] <= cmd_op;
        p0_log[n_log[8:0]] <= cmd_p0;
        n_log <= n_log + 1;
      end
      if (seq_done)   done_cnt <= done_cnt + 1;
      if (seq_err)    err_cnt  <= err_cnt + 1;
      if (seq_reject) rej_cnt  <= rej_cnt + 1;
    end
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    cmd_ready <= bp_en ? ((cyc % 3) != 0) : 1'b1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic req_pwr(input logic on);
    @(negedge clk); pwr_on = on; pwr_req = 1'b1;
    @(negedge clk); pwr_req = 1'b0;
  endtask

  task automatic req_mode(input int w);
    @(negedge clk); hres = 12'(w); mode_req = 1'b1;
    @(negedge clk); mode_req = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R4 busy", busy, 0);
    chk("R4 valid", cmd_valid, 0);
    chk("R4 pulses", {seq_done, seq_err, seq_reject}, 0);
  endtask

  task automatic t_power_up_full();
    int b = n_log, d = done_cnt;
    invert_en = 1'b1;
    req_pwr(1'b1);
    wait_idle();
    chk("R1 count", n_log - b, 24);
    chk("R1 first on", op_log[b], 8'h29);
    chk("R1 reset", op_log[b+4], 8'h01);
    chk("R2 pt first", op_log[b+8], 8'hB0);
    chk("R4 default full", p0_log[b+9], 8'h80);
    chk("R2 cfg", op_log[b+13], 8'hB8);
    chk("R2 timing", op_log[b+19], 8'hCF);
    chk("R8 invert kept", op_log[b+22], 8'h21);
    chk("R2 last", op_log[b+23], 8'h29);
    chk("R12 done once", done_cnt - d, 1);
  endtask

  task automatic t_same_power();
    int b = n_log; int saw = 0;
    req_pwr(1'b1);
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (busy) saw = 1; end
    chk("R5 no busy", saw, 0);
    chk("R5 no cmds", n_log - b, 0);
  endtask

  task automatic t_mode_quarter();
    int b = n_log;
    req_mode(320);
    wait_idle();
    chk("R6 count", n_log - b, 16);
    chk("R6 pt", op_log[b], 8'hB0);
    chk("R6 quarter param", p0_log[b+1], 8'h81);
    chk("R2 cfg after pt", op_log[b+5], 8'hB8);
    chk("R2 quarter timing", op_log[b+11], 8'hD6);
    chk("R8 invert kept", op_log[b+14], 8'h21);
  endtask

  task automatic t_mode_same(input int w);
    int b = n_log; int saw = 0;
    req_mode(w);
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (busy) saw = 1; end
    chk("R7 no busy", saw, 0);
    chk("R7 no cmds", n_log - b, 0);
  endtask

  task automatic t_mode_full();
    int b = n_log;
    req_mode(480);
    wait_idle();
    chk("R6 count full", n_log - b, 16);
    chk("R6 full param", p0_log[b+1], 8'h80);
    chk("R6 full timing", op_log[b+11], 8'hCF);
  endtask

  task automatic t_off_with_reject();
    int b = n_log, r = rej_cnt;
    req_pwr(1'b0);
    chk("R10 busy", busy, 1);
    req_mode(320);
    wait_idle();
    chk("R10 reject", rej_cnt - r, 1);
    chk("R3 count", n_log - b, 4);
    chk("R3 first", op_log[b], 8'h28);
    t_mode_same(640);
  endtask

  task automatic t_up_no_invert_bp();
    int b = n_log; int seen21 = 0;
    invert_en = 1'b0; bp_en = 1'b1;
    req_pwr(1'b1);
    wait_idle();
    bp_en = 1'b0;
    for (int i = 0; i < 23; i++) if (op_log[b+i] == 8'h21) seen21 = 1;
    chk("R8 count", n_log - b, 23);
    chk("R8 no 0x21", seen21, 0);
    chk("R11 order", op_log[b+21], 8'hD5);
    chk("R11 last", op_log[b+22], 8'h29);
    invert_en = 1'b1;
    req_pwr(1'b0);
    wait_idle();
  endtask

  task automatic t_error_abort();
    int b = n_log, d = done_cnt, e = err_cnt;
    req_pwr(1'b1);
    for (int i = 0; i < 200 && (n_log - b) < 5; i++) @(negedge clk);
    xfer_err = 1'b1;
    @(negedge clk); xfer_err = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 stopped", n_log - b, 5);
    chk("R9 err pulse", err_cnt - e, 1);
    chk("R9 no done", done_cnt - d, 0);
    chk("R9 idle", busy, 0);
    b = n_log;
    req_pwr(1'b1);
    wait_idle();
    chk("R9 retry runs", n_log - b, 24);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_power_up_full();
    t_same_power();
    t_mode_quarter();
    t_mode_same(240);
    t_mode_full();
    t_off_with_reject();
    t_up_no_invert_bp();
    t_error_abort();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule